// File: doc/BRIEF.md
# Matrix Keypad Scanner with Tick-Qualified Debounce

This block serves a grid keypad wired as rows and columns. It walks the column lines, driving one low at a time, and watches the row lines, which pull-ups hold high when no key connects them to a column. A pressed key therefore pulls its row low while its column is the active one. The row lines pass through a two-stage synchroniser before any decision is taken on them.

When a low row is seen, the column walk stops on the current column. A small state machine then waits for a periodic enable tick, nominally every 10 ms, and accepts the key only once the row has stayed low across several ticks. It then reports one code with a strobe one clock wide. No further report follows until the key has gone up and that release has been qualified by the same tick rule. Short contacts and short drop-outs are absorbed. The column walk resumes only after the release is accepted.

Top module: `kp_scanner`

## Requirements
- R1: While and right after reset, `key_valid` is 0 and `col_n` drives column 0 low with all other columns high (`col_n` = 4'b1110 for four columns).
- R2: At every cycle out of reset, exactly one bit of `col_n` is 0. Bit j of `col_n` is column j.
- R3: While no key is down, the low column moves to the next index every SCAN_DIV cycles, in the order 0, 1, ..., NUM_COLS-1, then back to 0.
- R4: An accepted key is reported as `key_code` = row × NUM_COLS + column. The row is the bit index in `row_n` that reads 0, and the column is the low bit of `col_n`.
- R5: `key_valid` is high for exactly one clock per accepted press, and `key_code` is valid in that cycle.
- R6: A press that stays down is reported between (STABLE_TICKS-1)×TICK_DIV and STABLE_TICKS×TICK_DIV + NUM_COLS×SCAN_DIV + 8 cycles after the row first goes low.
- R7: A contact that lasts fewer than (STABLE_TICKS-1)×TICK_DIV cycles produces no report.
- R8: While an accepted key is held, no second report is made and `col_n` stays on that key's column.
- R9: A release shorter than (STABLE_TICKS-1)×TICK_DIV cycles, followed by the same key pressed again, produces no new report.
- R10: Once a release has been held for STABLE_TICKS tick intervals, the next press of any key is reported again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | NUM_ROWS | Row lines, pulled high; a pressed key on the active column reads 0 |
| col_n | output | NUM_COLS | Column drive, active column 0, others 1 |
| key_valid | output | 1 | One-clock strobe for an accepted press |
| key_code | output | clog2(NUM_ROWS×NUM_COLS) | Code of the accepted key, row × NUM_COLS + column |

## Verification
The hardest state to reach is a release drop-out inside a held key. The key must first be accepted, and the row must then go high for a span shorter than one tick interval while the column is still frozen on that key. After that the same key must come back down. The bench uses a small tick and scan divisor. It models the keypad as a switch that reads the live `col_n`, so the row only reads low while the key's column is driven. A timed drop-out of 20 cycles, inside a 64-cycle tick interval, lands the machine in its release-qualifying state and then sends it back to the held state. The bench then counts the strobes.

// File: rtl/kp_pkg.sv
package kp_pkg;

    // Number of flops between the row pins and the decision logic
    localparam int SYNC_STAGES = 2;

    // Debounce machine states
    typedef enum logic [1:0] {
        KS_IDLE,     // scanning, no key under qualification
        KS_CONFIRM,  // row low seen, waiting for enough ticks
        KS_HELD,     // key accepted and still down
        KS_RELEASE   // row went high, qualifying the release
    } kp_state_e;

    // Width of a counter or index covering n values, at least one bit
    function automatic int kp_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync
    import kp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    // Reset to the pulled-up idle level so no false press appears at start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/kp_tick_gen.sv
module kp_tick_gen
    import kp_pkg::*;
#(
    parameter int TICK_DIV = 1_250_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int TW = kp_w(TICK_DIV);

    generate
        if (TICK_DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divided
            logic [TW-1:0] cnt_q;
            logic          wrap;

            assign wrap = (cnt_q == TW'(TICK_DIV - 1));

            always_ff @(posedge clk) begin
                if (rst)       cnt_q <= '0;
                else if (wrap) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end

            assign tick = wrap;

            // Ticks are isolated pulses, so a qualification span is real time
            p_tick_gap_r6 : assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/kp_col_scan.sv
module kp_col_scan
    import kp_pkg::*;
#(
    parameter int NUM_COLS = 4,
    parameter int SCAN_DIV = 125_000,
    localparam int CW = kp_w(NUM_COLS),
    localparam int DW = kp_w(SCAN_DIV)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    output logic [CW-1:0]       col_idx,
    output logic [NUM_COLS-1:0] col_n,
    output logic                settled
);

    logic [DW-1:0] dwell_q;
    logic          step;
    logic [CW-1:0] idx_next;

    assign step     = !hold && (dwell_q == DW'(SCAN_DIV - 1));
    assign idx_next = (col_idx == CW'(NUM_COLS - 1)) ? '0 : col_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_q <= '0;
            col_idx <= '0;
            col_n   <= ~NUM_COLS'(1);
        end else if (hold) begin
            dwell_q <= dwell_q;
        end else if (step) begin
            dwell_q <= '0;
            col_idx <= idx_next;
            col_n   <= ~(NUM_COLS'(1) << idx_next);
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    // Rows seen through the synchroniser belong to this column only after
    // SYNC_STAGES cycles of dwell
    assign settled = (dwell_q >= DW'(SYNC_STAGES));

    p_one_low_r2 : assert property (@(posedge clk) disable iff (rst)
        $countones(~col_n) == 1);

    p_col_step_r3 : assert property (@(posedge clk) disable iff (rst)
        step |=> (col_idx == (($past(col_idx) == CW'(NUM_COLS - 1)) ? '0 : $past(col_idx) + 1'b1)));

    p_hold_stable_r8 : assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(col_n));

endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
    import kp_pkg::*;
#(
    parameter int NUM_ROWS     = 4,
    parameter int NUM_COLS     = 4,
    parameter int STABLE_TICKS = 2,
    localparam int RW     = kp_w(NUM_ROWS),
    localparam int CW     = kp_w(NUM_COLS),
    localparam int NW     = kp_w(STABLE_TICKS),
    localparam int CODE_W = kp_w(NUM_ROWS * NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_ROWS-1:0] row_s,
    input  logic [CW-1:0]       col_idx,
    input  logic                settled,
    input  logic                tick,
    output logic                freeze,
    output logic                key_valid,
    output logic [CODE_W-1:0]   key_code
);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } cand_t;

    kp_state_e         state_q, state_d;
    logic [NW-1:0]     cnt_q, cnt_d;
    cand_t             cand_q, cand_d;
    logic              valid_d;
    logic [CODE_W-1:0] code_d;

    logic              any_low;
    logic [RW-1:0]     low_row;
    logic              cand_up;
    logic              detect;
    logic              enough;

    // Lowest-numbered low row wins
    always_comb begin
        low_row = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (!row_s[i]) low_row = RW'(i);
        end
    end

    assign any_low = ~&row_s;
    assign cand_up = row_s[cand_q.row];
    assign detect  = (state_q == KS_IDLE) && settled && any_low;
    assign freeze  = (state_q != KS_IDLE) || detect;
    assign enough  = (cnt_q == NW'(STABLE_TICKS - 1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cand_d  = cand_q;
        valid_d = 1'b0;
        code_d  = key_code;
        unique case (state_q)
            KS_IDLE: begin
                if (detect) begin
                    state_d = KS_CONFIRM;
                    cnt_d   = '0;
                    cand_d  = '{row: low_row, col: col_idx};
                end
            end
            KS_CONFIRM: begin
                if (cand_up) begin
                    state_d = KS_IDLE;
                end else if (tick) begin
                    if (enough) begin
                        state_d = KS_HELD;
                        valid_d = 1'b1;
                        code_d  = CODE_W'(cand_q.row) * CODE_W'(NUM_COLS) + CODE_W'(cand_q.col);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            KS_HELD: begin
                if (cand_up) begin
                    state_d = KS_RELEASE;
                    cnt_d   = '0;
                end
            end
            KS_RELEASE: begin
                if (!cand_up) begin
                    state_d = KS_HELD;
                end else if (tick) begin
                    if (enough) state_d = KS_IDLE;
                    else        cnt_d   = cnt_q + 1'b1;
                end
            end
            default: state_d = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= KS_IDLE;
            cnt_q     <= '0;
            cand_q    <= '0;
            key_valid <= 1'b0;
            key_code  <= '0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            cand_q    <= cand_d;
            key_valid <= valid_d;
            key_code  <= code_d;
        end
    end

    p_valid_single_r5 : assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    p_valid_on_tick_r6 : assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ($past(tick) && $past(state_q) == KS_CONFIRM));

    p_held_quiet_r8 : assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == KS_HELD || $past(state_q) == KS_RELEASE) |-> !key_valid);

    p_dropout_back_r9 : assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_RELEASE && !cand_up) |=> state_q == KS_HELD);

    p_release_on_tick_r10 : assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_IDLE && $past(state_q) == KS_RELEASE) |-> $past(tick));

endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
    import kp_pkg::*;
#(
    parameter int NUM_ROWS     = 4,
    parameter int NUM_COLS     = 4,
    parameter int SCAN_DIV     = 125_000,
    parameter int TICK_DIV     = 1_250_000,
    parameter int STABLE_TICKS = 2,
    localparam int CODE_W = kp_w(NUM_ROWS * NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_ROWS-1:0] row_n,
    output logic [NUM_COLS-1:0] col_n,
    output logic                key_valid,
    output logic [CODE_W-1:0]   key_code
);

    localparam int CW = kp_w(NUM_COLS);

    logic [NUM_ROWS-1:0] row_s;
    logic [CW-1:0]       col_idx;
    logic                settled;
    logic                tick;
    logic                freeze;

    kp_row_sync #(.WIDTH(NUM_ROWS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (row_n),
        .dout (row_s)
    );

    kp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    kp_col_scan #(.NUM_COLS(NUM_COLS), .SCAN_DIV(SCAN_DIV)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .hold    (freeze),
        .col_idx (col_idx),
        .col_n   (col_n),
        .settled (settled)
    );

    kp_debounce #(
        .NUM_ROWS     (NUM_ROWS),
        .NUM_COLS     (NUM_COLS),
        .STABLE_TICKS (STABLE_TICKS)
    ) u_deb (
        .clk       (clk),
        .rst       (rst),
        .row_s     (row_s),
        .col_idx   (col_idx),
        .settled   (settled),
        .tick      (tick),
        .freeze    (freeze),
        .key_valid (key_valid),
        .key_code  (key_code)
    );

    p_reset_quiet_r1 : assert property (@(posedge clk)
        $past(rst) |-> (!key_valid && col_n == ~NUM_COLS'(1)));

endmodule

// File: tb/kp_scanner_bench.sv
module kp_scanner_bench;

    localparam int NR = 4;
    localparam int NC = 4;
    localparam int SD = 8;
    localparam int TD = 64;
    localparam int ST = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] row_n;
    logic [NC-1:0] col_n;
    logic          key_valid;
    logic [3:0]    key_code;

    always #4 clk = ~clk;

    // Keypad model: one switch at (kr, kc), pulled-up rows
    logic key_down = 1'b0;
    int   kr = 0;
    int   kc = 0;
    always_comb begin
        row_n = '1;
        if (key_down && col_n[kc] == 1'b0) row_n[kr] = 1'b0;
    end

    kp_scanner #(
        .NUM_ROWS(NR), .NUM_COLS(NC), .SCAN_DIV(SD),
        .TICK_DIV(TD), .STABLE_TICKS(ST)
    ) u_kp_scanner (
        .clk(clk), .rst(rst), .row_n(row_n),
        .col_n(col_n), .key_valid(key_valid), .key_code(key_code)
    );

    int      n_checks = 0;
    int      n_fail   = 0;
    longint  cyc = 0;
    int      pulses = 0;
    logic [3:0] last_code = '0;
    longint  last_vcyc = 0;
    int      onehot_bad = 0;
    int      double_valid = 0;
    logic    prev_valid = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if ($countones(~col_n) != 1) onehot_bad++;
            if (key_valid) begin
                pulses++;
                last_code = key_code;
                last_vcyc = cyc;
                if (prev_valid) double_valid++;
            end
            prev_valid = key_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int col_of(input logic [NC-1:0] c);
        int r = -1;
        for (int j = NC - 1; j >= 0; j--) if (!c[j]) r = j;
        return r;
    endfunction

    task automatic press_full(input int r, input int c);
        int     p0;
        longint pcyc;
        longint lat;
        @(negedge clk);
        kr = r; kc = c;
        p0 = pulses;
        pcyc = cyc;
        key_down = 1'b1;
        wait_cyc(ST * TD + NC * SD + 16);
        check(pulses - p0 == 1, "R5", "strobes per press", pulses - p0, 1);
        check(last_code == 4'(r * NC + c), "R4", "key code", last_code, r * NC + c);
        lat = last_vcyc - pcyc;
        check(lat >= (ST - 1) * TD && lat <= ST * TD + NC * SD + 8, "R6",
              "press latency", lat, ST * TD);
        check(col_n == ~(NC'(1) << c), "R8", "column frozen", col_n, ~(NC'(1) << c));
        wait_cyc(3 * TD);
        check(pulses - p0 == 1, "R8", "no repeat while held", pulses - p0, 1);
        key_down = 1'b0;
        wait_cyc((ST + 1) * TD + 8);
    endtask

    initial begin : main
        int prev_idx;
        int gap;
        int changes;
        int order_bad;
        int p1;

        wait_cyc(3);
        // R1: state held by reset
        check(key_valid == 1'b0, "R1", "key_valid in reset", key_valid, 0);
        check(col_n == 4'b1110, "R1", "col_n in reset", col_n, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        check(col_n == 4'b1110, "R1", "col_n after reset", col_n, 4'b1110);

        // R3: ordered stepping every SD cycles with no key down
        prev_idx = col_of(col_n);
        gap = 0; changes = 0; order_bad = 0;
        for (int k = 0; k < 6 * NC * SD; k++) begin
            @(negedge clk);
            gap++;
            if (col_of(col_n) != prev_idx) begin
                if (col_of(col_n) != (prev_idx + 1) % NC) order_bad++;
                if (changes > 0 && gap != SD) order_bad++;
                changes++;
                gap = 0;
                prev_idx = col_of(col_n);
            end
        end
        check(order_bad == 0, "R3", "step order/spacing errors", order_bad, 0);
        check(changes >= 5 * NC, "R3", "column steps seen", changes, 6 * NC);

        // R4 R5 R6 R8 R10: every key in turn, each after a qualified release
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                press_full(r, c);

        // R7: brief contact while its column is driven
        p1 = pulses;
        for (int k = 0; k < 4 * NC * SD && col_n[2] != 1'b0; k++) @(negedge clk);
        kr = 1; kc = 2;
        key_down = 1'b1;
        wait_cyc(20);
        key_down = 1'b0;
        wait_cyc(4 * TD);
        check(pulses == p1, "R7", "strobes after brief contact", pulses - p1, 0);

        // R9: short drop-out during a held key
        @(negedge clk);
        kr = 3; kc = 1;
        key_down = 1'b1;
        wait_cyc(ST * TD + NC * SD + 16);
        p1 = pulses;
        key_down = 1'b0;
        wait_cyc(20);
        key_down = 1'b1;
        wait_cyc(3 * TD);
        check(pulses == p1, "R9", "strobes after drop-out", pulses - p1, 0);
        key_down = 1'b0;
        wait_cyc((ST + 1) * TD + 8);

        // R10: after a qualified release a fresh press reports again
        @(negedge clk);
        kr = 2; kc = 3;
        key_down = 1'b1;
        wait_cyc(ST * TD + NC * SD + 16);
        check(pulses == p1 + 1, "R10", "strobes after full release", pulses - p1, 1);
        check(last_code == 4'(2 * NC + 3), "R10", "code after full release", last_code, 2 * NC + 3);
        key_down = 1'b0;
        wait_cyc((ST + 1) * TD + 8);

        check(onehot_bad == 0, "R2", "cycles without one low column", onehot_bad, 0);
        check(double_valid == 0, "R5", "back-to-back strobes", double_valid, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150_000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150_000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule